// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter-gather segments (a 32-bit bus address plus a 32-bit byte length, offered over a valid/ready handshake) into bus-master descriptor entries. Each entry is an address word and a count word, released over a second valid/ready handshake. Segments are cut so that no entry ever crosses a 64 KB boundary. In the normal mode a full 64 KB piece is emitted as two 32 KB entries, because some controllers read a count of zero as zero bytes. The last entry of a table carries an end flag in bit 31 of its count word.

A request is a run of segments closed by one with `seg_last` high. The builder counts entries against a capacity parameter. When the table completes it pulses `done` with the entry count. It pulses an error instead when the table overflows, ends up empty, or holds a misaligned segment, and the requester then falls back to programmed I/O. The `alt_mode` input selects a controller variant. That variant packs the count as a word count minus one into the upper half, needs 32-bit alignment, and sets no end flag.

The control is one state machine. `ST_IDLE` accepts a segment and moves to `ST_GEN`, or stays put when the segment is misaligned. `ST_GEN` emits one entry per free output slot and returns to `ST_IDLE` when the segment is used up and more segments follow. It goes to `ST_FLUSH` when the segment closes the request, and to `ST_IDLE` with an overflow error when the capacity is reached. `ST_FLUSH` releases the held entry with the end flag and moves to `ST_DONE`, or reports an empty table and moves to `ST_IDLE`. `ST_DONE` waits for the last entry to be taken, pulses `done`, and returns to `ST_IDLE`. The newest entry is always held back one step, so the end flag can still be patched into it once the request is known to be over.

Top module: `sg_table_builder`

## Requirements
- R1: Each entry covers min(0x10000 − addr[15:0], remaining length) bytes, so no entry crosses a 64 KB boundary. The next entry starts at the previous address plus that length.
- R2: In normal mode, count word bits [15:0] hold the byte count and bits [30:16] are zero.
- R3: In normal mode, a 64 KB piece is emitted as two entries with count 0x8000, at address A and at A+0x8000.
- R4: In normal mode, bit 31 of the count word is set on the final entry of the table and on no other entry. If the segment marked `seg_last` has zero length, the flag lands on the previous entry.
- R5: Every entry, including each half of a split, counts against CAP (default 256). A table of exactly CAP entries completes. Needing entry CAP+1 pulses `err_overflow` and no `done`.
- R6: With `alt_mode` high, the count word is ((bytes/4) − 1) in bits [31:16] with bits [15:0] zero. No end flag is set, and a 64 KB piece stays one entry (0x3FFF0000).
- R7: A request that yields no entries pulses `err_empty` and no `done`.
- R8: A segment with an odd address or length in normal mode, or with either not a multiple of 4 in alternate mode, pulses `err_align`, is consumed, and produces no entry.
- R9: After the last entry is accepted, `done` pulses for one cycle with `done_entries` equal to the number of entries. At most one of `done`, `err_overflow`, `err_empty` and `err_align` is high in any cycle.
- R10: After reset, `ent_valid` is 0, `seg_ready` is 1 and all pulses are 0. While `ent_valid` is high and `ent_ready` is low, the entry holds steady, so results do not depend on backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | Alternate count encoding, sampled with each segment |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment byte length |
| seg_last | input | 1 | Segment closes the request |
| ent_valid | output | 1 | Entry offered |
| ent_ready | input | 1 | Entry taken this cycle when valid |
| ent_addr | output | 32 | Entry address word |
| ent_count | output | 32 | Entry count word |
| done | output | 1 | Table complete pulse |
| done_entries | output | 9 | Number of entries in the completed table |
| err_overflow | output | 1 | Capacity exceeded pulse |
| err_empty | output | 1 | Empty table pulse |
| err_align | output | 1 | Misaligned segment pulse |

## Verification
Single-segment vectors check the splitting. A short segment tells the boundary cut apart from a plain pass-through. An address just below a 64 KB line shows whether the distance to the boundary is used. Aligned and unaligned 64 KB lengths separate the 32 KB split from the boundary cut. The same lengths in alternate mode show that its encoding replaces the split and drops the flag. Multi-segment requests, one ending in a zero-length segment, show that the end flag follows the request and not the segment. Tables of exactly CAP and CAP+2 entries pin the capacity edge. Half of the vectors run under toggling backpressure and must give identical results.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GEN,
        ST_FLUSH,
        ST_DONE
    } sgb_state_e;
endpackage

// File: rtl/sgb_chunk.sv
// Combinational sizing of the next descriptor: distance to the boundary,
// capped by the remaining length, halved for full pieces in normal mode.
module sgb_chunk #(
    parameter int DW = 32,
    parameter int BW = 16
) (
    input  logic [BW-1:0] addr_lo,
    input  logic [DW-1:0] rem,
    input  logic          alt,
    output logic [BW:0]   chunk,
    output logic [DW-1:0] cnt_word
);
    localparam int HW = DW - BW;

    logic [BW:0]   to_bound;
    logic [BW:0]   raw;
    logic [HW-1:0] words_m1;

    always_comb begin
        to_bound = {1'b1, {BW{1'b0}}} - {1'b0, addr_lo};
        raw      = (rem < DW'(to_bound)) ? rem[BW:0] : to_bound;
        if (!alt && raw[BW])
            chunk = (BW+1)'(1) << (BW-1);
        else
            chunk = raw;
        words_m1 = HW'(chunk >> 2) - HW'(1);
        if (alt)
            cnt_word = {words_m1, {BW{1'b0}}};
        else
            cnt_word = {{HW{1'b0}}, chunk[BW-1:0]};
    end
endmodule

// File: rtl/sgb_capacity.sv
// Entry counter against the table capacity.
module sgb_capacity #(
    parameter int CAP = 256,
    parameter int CW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + CW'(1);
    end

    assign full = (count == CW'(CAP));

    // R5: the table never holds more than CAP entries
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(CAP));
    // R5: no entry is added once the table is full
    p_no_inc_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !inc);
endmodule

// File: rtl/sg_table_builder.sv
module sg_table_builder #(
    parameter int CAP = 256,
    parameter int DW  = 32,
    parameter int BW  = 16,
    parameter int CW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alt_mode,
    input  logic          seg_valid,
    output logic          seg_ready,
    input  logic [DW-1:0] seg_addr,
    input  logic [DW-1:0] seg_len,
    input  logic          seg_last,
    output logic          ent_valid,
    input  logic          ent_ready,
    output logic [DW-1:0] ent_addr,
    output logic [DW-1:0] ent_count,
    output logic          done,
    output logic [CW-1:0] done_entries,
    output logic          err_overflow,
    output logic          err_empty,
    output logic          err_align
);
    import sgb_pkg::*;

    localparam logic [DW-1:0] END_FLAG = {1'b1, {(DW-1){1'b0}}};

    sgb_state_e state, state_nx;

    logic [DW-1:0] cur_addr, rem;
    logic          last_r, alt_r;
    logic          pend_valid;
    logic [DW-1:0] pend_addr, pend_cnt;
    logic          out_alt;
    logic          slot_free, misaligned;
    logic          accept, bad_align, produce, overflow, flush, empty, finish;
    logic [BW:0]   chunk;
    logic [DW-1:0] chunk_cnt;
    logic [CW-1:0] cap_count;
    logic          cap_full, cap_clr;

    sgb_chunk #(.DW(DW), .BW(BW)) u_chunk (
        .addr_lo  (cur_addr[BW-1:0]),
        .rem      (rem),
        .alt      (alt_r),
        .chunk    (chunk),
        .cnt_word (chunk_cnt)
    );

    sgb_capacity #(.CAP(CAP), .CW(CW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (produce),
        .clr   (cap_clr),
        .count (cap_count),
        .full  (cap_full)
    );

    assign seg_ready  = (state == ST_IDLE);
    assign slot_free  = !ent_valid || ent_ready;
    assign misaligned = alt_mode ? ((seg_addr[1:0] != 2'b00) || (seg_len[1:0] != 2'b00))
                                 : (seg_addr[0] || seg_len[0]);
    assign cap_clr    = bad_align || overflow || empty || finish;

    // next-state and control strobes
    always_comb begin
        state_nx  = state;
        accept    = 1'b0;
        bad_align = 1'b0;
        produce   = 1'b0;
        overflow  = 1'b0;
        flush     = 1'b0;
        empty     = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (seg_valid) begin
                    accept = 1'b1;
                    if (misaligned) bad_align = 1'b1;
                    else            state_nx  = ST_GEN;
                end
            end
            ST_GEN: begin
                if (rem == '0) begin
                    state_nx = last_r ? ST_FLUSH : ST_IDLE;
                end else if (slot_free) begin
                    if (cap_full) begin
                        overflow = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        produce = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (slot_free) begin
                    if (pend_valid) begin
                        flush    = 1'b1;
                        state_nx = ST_DONE;
                    end else begin
                        empty    = 1'b1;
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_DONE: begin
                if (!ent_valid) begin
                    finish   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr     <= '0;
            rem          <= '0;
            last_r       <= 1'b0;
            alt_r        <= 1'b0;
            pend_valid   <= 1'b0;
            pend_addr    <= '0;
            pend_cnt     <= '0;
            ent_valid    <= 1'b0;
            ent_addr     <= '0;
            ent_count    <= '0;
            out_alt      <= 1'b0;
            done         <= 1'b0;
            done_entries <= '0;
            err_overflow <= 1'b0;
            err_empty    <= 1'b0;
            err_align    <= 1'b0;
        end else begin
            done         <= finish;
            err_overflow <= overflow;
            err_empty    <= empty;
            err_align    <= bad_align;
            if (finish) done_entries <= cap_count;

            if (accept && !bad_align) begin
                cur_addr <= seg_addr;
                rem      <= seg_len;
                last_r   <= seg_last;
                alt_r    <= alt_mode;
            end

            if (produce) begin
                cur_addr   <= cur_addr + DW'(chunk);
                rem        <= rem - DW'(chunk);
                pend_addr  <= cur_addr;
                pend_cnt   <= chunk_cnt;
                pend_valid <= 1'b1;
            end else if (cap_clr || flush) begin
                pend_valid <= 1'b0;
            end

            if ((produce && pend_valid) || flush) begin
                ent_valid <= 1'b1;
                ent_addr  <= pend_addr;
                ent_count <= (flush && !alt_r) ? (pend_cnt | END_FLAG) : pend_cnt;
                out_alt   <= alt_r;
            end else if (ent_ready) begin
                ent_valid <= 1'b0;
            end
        end
    end

    // R1: a normal-mode entry stays inside its 64 KB window
    p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && !out_alt) |->
            (({1'b0, ent_addr[BW-1:0]} + {1'b0, ent_count[BW-1:0]}) <= {1'b1, {BW{1'b0}}}));
    // R3: a normal-mode count field is never zero
    p_no_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && !out_alt) |-> (ent_count[BW-1:0] != '0));
    // R6: alternate entries carry no flag and an empty low half
    p_alt_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && out_alt) |-> (!ent_count[DW-1] && (ent_count[BW-1:0] == '0)));
    // R9: at most one outcome per cycle
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_overflow, err_empty, err_align}));
    // R10: an offered entry holds until it is taken
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_addr) && $stable(ent_count)));
endmodule

// File: tb/test_sg_table_builder.sv
`timescale 1ns/1ps
module test_sg_table_builder;
    localparam int CAP = 256;
    localparam int CW  = $clog2(CAP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_mode = 1'b0;
    logic          seg_valid = 1'b0;
    logic          seg_ready;
    logic [31:0]   seg_addr = '0;
    logic [31:0]   seg_len = '0;
    logic          seg_last = 1'b0;
    logic          ent_valid;
    logic          ent_ready = 1'b0;
    logic [31:0]   ent_addr, ent_count;
    logic          done;
    logic [CW-1:0] done_entries;
    logic          err_overflow, err_empty, err_align;

    always #4 clk = ~clk;

    sg_table_builder #(.CAP(CAP)) i_sg_table_builder (
        .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr),
        .ent_count(ent_count), .done(done), .done_entries(done_entries),
        .err_overflow(err_overflow), .err_empty(err_empty), .err_align(err_align)
    );

    int checks = 0;
    int fails  = 0;

    // monitor state
    logic        bp_mode = 1'b0;
    int          got_n, got_flags, got_entries;
    logic        got_done;
    logic [1:0]  got_err;
    logic [31:0] f_addr, f_cnt, l_addr, l_cnt;

    always @(negedge clk) begin
        ent_ready = bp_mode ? ~ent_ready : 1'b1;
        if (ent_valid && ent_ready) begin
            if (got_n == 0) begin f_addr = ent_addr; f_cnt = ent_count; end
            l_addr = ent_addr;
            l_cnt  = ent_count;
            got_n++;
            if (ent_count[31]) got_flags++;
        end
        if (done) begin got_done = 1'b1; got_entries = int'(done_entries); end
        if (err_align)    got_err = 2'd1;
        if (err_empty)    got_err = 2'd2;
        if (err_overflow) got_err = 2'd3;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        got_n = 0; got_flags = 0; got_entries = 0; got_done = 1'b0; got_err = 2'd0;
        f_addr = '0; f_cnt = '0; l_addr = '0; l_cnt = '0;
    endtask

    task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input logic last, input logic alt);
        @(posedge clk); #1;
        seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last; alt_mode = alt;
        while (!seg_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        seg_valid = 1'b0;
    endtask

    task automatic wait_outcome();
        int k = 0;
        while (!got_done && got_err == 2'd0 && k < 20000) begin @(posedge clk); k++; end
        repeat (4) @(posedge clk);
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] len;
        logic        alt;
        logic [9:0]  n;
        logic [31:0] fcnt;
        logic [31:0] laddr;
        logic [31:0] lcnt;
        logic [1:0]  err;   // 0 done, 1 align, 2 empty, 3 overflow
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_0000, 32'h200,   1'b0, 10'd1, 32'h8000_0200, 32'h1000_0000, 32'h8000_0200, 2'd0}, // R2 R4
        '{32'h0001_FF00, 32'h300,   1'b0, 10'd2, 32'h0000_0100, 32'h0002_0000, 32'h8000_0200, 2'd0}, // R1
        '{32'h0002_0000, 32'h10000, 1'b0, 10'd2, 32'h0000_8000, 32'h0002_8000, 32'h8000_8000, 2'd0}, // R3
        '{32'h0003_0000, 32'h10000, 1'b1, 10'd1, 32'h3FFF_0000, 32'h0003_0000, 32'h3FFF_0000, 2'd0}, // R6
        '{32'h0004_0010, 32'h20,    1'b1, 10'd1, 32'h0007_0000, 32'h0004_0010, 32'h0007_0000, 2'd0}, // R6
        '{32'h0005_FFF0, 32'h20,    1'b1, 10'd2, 32'h0003_0000, 32'h0006_0000, 32'h0003_0000, 2'd0}, // R1 R6
        '{32'h0000_0001, 32'h4,     1'b0, 10'd0, 32'h0,         32'h0,         32'h0,         2'd1}, // R8
        '{32'h0000_0100, 32'h3,     1'b0, 10'd0, 32'h0,         32'h0,         32'h0,         2'd1}, // R8
        '{32'h0000_0102, 32'h4,     1'b1, 10'd0, 32'h0,         32'h0,         32'h0,         2'd1}, // R8
        '{32'h0000_0000, 32'h0,     1'b0, 10'd0, 32'h0,         32'h0,         32'h0,         2'd2}, // R7
        '{32'h0008_8000, 32'h18000, 1'b0, 10'd3, 32'h0000_8000, 32'h0009_8000, 32'h8000_8000, 2'd0}  // R1 R3
    };

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R10 reset state
        check(ent_valid == 1'b0, "R10 reset ent_valid", 32'(ent_valid), 32'h0);
        check(seg_ready == 1'b1, "R10 reset seg_ready", 32'(seg_ready), 32'h1);
        check({done, err_overflow, err_empty, err_align} == 4'b0, "R10 reset pulses",
              32'({done, err_overflow, err_empty, err_align}), 32'h0);

        // vector walk: R1 R2 R3 R4 R6 R7 R8 R9, odd vectors under backpressure (R10)
        for (int i = 0; i < NV; i++) begin
            bp_mode = (i % 2) == 1;
            clear_mon();
            send_seg(VECS[i].addr, VECS[i].len, 1'b1, VECS[i].alt);
            wait_outcome();
            check(got_err == VECS[i].err, $sformatf("R7/R8/R9 vector %0d outcome", i), 32'(got_err), 32'(VECS[i].err));
            check(got_n == int'(VECS[i].n), $sformatf("R1 vector %0d entry count", i), got_n, 32'(VECS[i].n));
            if (VECS[i].err == 2'd0) begin
                check(got_done && got_entries == int'(VECS[i].n), $sformatf("R9 vector %0d done_entries", i),
                      got_entries, 32'(VECS[i].n));
                check(f_cnt == VECS[i].fcnt, $sformatf("R2/R6 vector %0d first count", i), f_cnt, VECS[i].fcnt);
                check(l_addr == VECS[i].laddr, $sformatf("R1/R3 vector %0d last addr", i), l_addr, VECS[i].laddr);
                check(l_cnt == VECS[i].lcnt, $sformatf("R4/R6 vector %0d last count", i), l_cnt, VECS[i].lcnt);
            end else begin
                check(!got_done, $sformatf("R9 vector %0d no done on error", i), 32'(got_done), 32'h0);
            end
        end
        bp_mode = 1'b0;

        // R4: zero-length closing segment puts the flag on the earlier entry
        clear_mon();
        send_seg(32'h1000, 32'h100, 1'b0, 1'b0);
        send_seg(32'h5000, 32'h0, 1'b1, 1'b0);
        wait_outcome();
        check(got_done && got_n == 1, "R4 zero-length tail entries", got_n, 32'd1);
        check(l_cnt == 32'h8000_0100, "R4 zero-length tail flag", l_cnt, 32'h8000_0100);

        // R4: two segments, flag only on the final entry
        clear_mon();
        send_seg(32'h1000, 32'h100, 1'b0, 1'b0);
        send_seg(32'h2000, 32'h40, 1'b1, 1'b0);
        wait_outcome();
        check(f_cnt == 32'h0000_0100, "R4 first segment no flag", f_cnt, 32'h100);
        check(l_cnt == 32'h8000_0040 && l_addr == 32'h2000, "R4 second segment flagged", l_cnt, 32'h8000_0040);
        check(got_flags == 1, "R4 single flag", got_flags, 32'd1);

        // R5: exactly CAP entries (128 full pieces, each split)
        clear_mon();
        send_seg(32'h0, 32'h80_0000, 1'b1, 1'b0);
        wait_outcome();
        check(got_done && got_entries == CAP, "R5 exact capacity done", got_entries, CAP);
        check(l_addr == 32'h7F_8000 && l_cnt == 32'h8000_8000, "R5 exact capacity last", l_cnt, 32'h8000_8000);

        // R5: one piece more overflows
        clear_mon();
        send_seg(32'h0, 32'h81_0000, 1'b1, 1'b0);
        wait_outcome();
        check(got_err == 2'd3, "R5 overflow error", 32'(got_err), 32'd3);
        check(!got_done, "R5 overflow no done", 32'(got_done), 32'h0);

        // R9: recovery after overflow
        clear_mon();
        send_seg(32'h3000, 32'h80, 1'b1, 1'b0);
        wait_outcome();
        check(got_done && got_entries == 1 && l_cnt == 32'h8000_0080, "R9 recovery table", l_cnt, 32'h8000_0080);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule